// File: doc/BRIEF.md
# Circuit-Switched Memory Gateway Sequencer

This block sits at a memory access point and serves read and write requests that processors send over an on-chip packet network. It does not carry the data in packets. For each request it reserves an end-to-end circuit, then moves the whole burst over that circuit. Competing requests are resolved by that reservation alone. The gateway works on one transaction at a time and holds any further request with ready/valid backpressure until the current circuit is released.

The two directions set up their circuits in different orders.

- **Read.** The gateway turns on two local path switches: command modulators to the module, and module to the network. It then sends a path-setup message toward the requester and waits for the path acknowledgement. After the acknowledgement it issues the row address and then the column address. It releases the circuit itself once the data time has passed. That time is a fixed latency plus the burst length times the beat time.
- **Write.** The request itself has already reserved the path from the processor. The gateway enables the modulators and sends both addresses. Only then does it switch the network-to-module path and acknowledge the processor. The processor side ends the transfer by signalling teardown.

If a read acknowledgement does not arrive within a programmable window, the transaction is abandoned and every switch is released.

Top module: `mgw_seq`

## Requirements
- R1: Outputs during and directly after reset:
  - `req_ready` is 1.
  - Every switch output is 0.
  - `setup_valid`, `ack_out`, `cmd_valid` and `abort_o` are 0.
- R2: Accepting requests:
  - A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
  - From the next cycle, `req_ready` stays 0 until the cycle after the transaction ends.
  - `req_valid` has no effect while `req_ready` is 0.
- R3: Read setup (`req_write`=0):
  - In the first cycle after acceptance, `sw_mod2mem` and `sw_mem2net` are 1.
  - In the second cycle, `setup_valid` is 1 for exactly one cycle, and `peer_id` equals the request's `req_src`.
- R4: Read commands:
  - No command is issued before the acknowledgement.
  - In the cycle after `ack_in` is sampled high, there is a row command: `cmd_kind`=1 and `cmd_addr` = the upper ROW_W bits of `req_addr`.
  - In the following cycle there is a read column command: `cmd_kind`=2 and `cmd_addr` = the lower COL_W bits.
- R5: Read data phase:
  - After the column cycle, `sw_mod2mem` is 0 and `sw_mem2net` stays 1 for exactly CL_CYC + `req_len`*BEAT_CYC cycles.
  - All switches are then 0 and `req_ready` is 1.
- R6: Read acknowledgement timeout:
  - The wait window is max(`to_limit`,1) cycles, starting the cycle after `setup_valid`.
  - An `ack_in` sampled in any cycle of the window, including the last, continues the read.
  - Otherwise `abort_o` is 1 for one cycle with all switches 0, and the next cycle is idle.
- R7: Write sequence (`req_write`=1), cycle by cycle after acceptance:
  1. `sw_mod2mem`=1.
  2. Row command (`cmd_kind`=1).
  3. Write column command (`cmd_kind`=3).
  4. `sw_mod2mem`=0 and `sw_net2mem`=1.
  5. `ack_out`=1 for one cycle, with `peer_id` = `req_src`.

  `sw_mem2net` and `sw_net2mem` are never both 1.
- R8: Write teardown:
  - After the acknowledgement, `sw_net2mem` stays 1 until `teardown_in` is sampled high; the next cycle is idle.
  - `teardown_in` has no effect at any other time, for example during a read data phase.
- R9: `ack_in` has no effect outside the read wait window. An acknowledgement given only during the `setup_valid` cycle does not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Gateway idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in the upper bits, column in the lower bits |
| req_len | input | LEN_W | Burst length in beats |
| req_src | input | SRC_W | Requesting processor identifier |
| to_limit | input | TO_W | Acknowledgement wait window in cycles (0 acts as 1) |
| sw_mod2mem | output | 1 | Switch: command modulators to module |
| sw_mem2net | output | 1 | Switch: module to network |
| sw_net2mem | output | 1 | Switch: network to module |
| setup_valid | output | 1 | Path-setup message toward requester |
| ack_in | input | 1 | Path acknowledgement from requester (read) |
| ack_out | output | 1 | Path acknowledgement to requester (write) |
| teardown_in | input | 1 | Requester releases the write path |
| peer_id | output | SRC_W | Requester of the current transaction |
| cmd_valid | output | 1 | Command to module valid |
| cmd_kind | output | 2 | 1 row, 2 read column, 3 write column |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column address, zero-extended |
| abort_o | output | 1 | One-cycle pulse on acknowledgement timeout |

## Verification
A wrong sequencer state shows at the switch, handshake or command outputs in the very next cycle, because every one of them decodes the current state directly. Each transaction is therefore followed cycle by cycle against a timeline built from the request:

- Read data duration errors appear as a `sw_mem2net` edge one cycle early or late.
- Timeout window errors appear as an abort pulse instead of a row command, or the reverse.
- An input acted on when it should be ignored changes the following cycle's switches or `req_ready`.

// File: rtl/mgw_pkg.sv
package mgw_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_SW,
      S_RD_SETUP,
      S_RD_WAIT,
      S_RD_ROW,
      S_RD_COL,
      S_RD_DATA,
      S_WR_MOD,
      S_WR_ROW,
      S_WR_COL,
      S_WR_NET,
      S_WR_ACK,
      S_WR_DATA,
      S_ABORT
   } gw_state_t;

   typedef enum logic [1:0] {
      CMD_NONE = 2'd0,
      CMD_ROW  = 2'd1,
      CMD_RD   = 2'd2,
      CMD_WR   = 2'd3
   } gw_cmd_t;

endpackage

// File: rtl/mgw_req_reg.sv
// Holds the fields of the accepted request for the life of the transaction.
module mgw_req_reg #(
   parameter int ROW_W = 14,
   parameter int COL_W = 10,
   parameter int LEN_W = 6,
   parameter int SRC_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [ROW_W-1:0] in_row,
   input  logic [COL_W-1:0] in_col,
   input  logic [LEN_W-1:0] in_len,
   input  logic [SRC_W-1:0] in_src,
   output logic [ROW_W-1:0] row,
   output logic [COL_W-1:0] col,
   output logic [LEN_W-1:0] len,
   output logic [SRC_W-1:0] src
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row <= '0;
         col <= '0;
         len <= '0;
         src <= '0;
      end else if (load) begin
         row <= in_row;
         col <= in_col;
         len <= in_len;
         src <= in_src;
      end
   end

endmodule

// File: rtl/mgw_timer.sv
// Loadable down counter shared by the acknowledgement window and the read data phase.
module mgw_timer #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (dec && (cnt != '0)) begin
         cnt <= cnt - W'(1);
      end
   end

   assign last = (cnt <= W'(1));

endmodule

// File: rtl/mgw_fsm.sv
// Transaction sequencer: all handshake, switch and command strobes decode the state.
module mgw_fsm
   import mgw_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req_valid,
   input  logic    req_write,
   input  logic    ack_in,
   input  logic    teardown_in,
   input  logic    tmr_last,
   output logic    accept,
   output logic    idle,
   output logic    tmr_load_wait,
   output logic    tmr_load_data,
   output logic    tmr_dec,
   output logic    sw_mod2mem,
   output logic    sw_mem2net,
   output logic    sw_net2mem,
   output logic    setup_valid,
   output logic    ack_out,
   output logic    abort_o,
   output logic    cmd_valid,
   output gw_cmd_t cmd_kind
);

   gw_state_t state, state_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) state <= S_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         S_IDLE:     if (req_valid) state_nx = req_write ? S_WR_MOD : S_RD_SW;
         S_RD_SW:    state_nx = S_RD_SETUP;
         S_RD_SETUP: state_nx = S_RD_WAIT;
         S_RD_WAIT: begin
            if (ack_in)        state_nx = S_RD_ROW;
            else if (tmr_last) state_nx = S_ABORT;
         end
         S_RD_ROW:   state_nx = S_RD_COL;
         S_RD_COL:   state_nx = S_RD_DATA;
         S_RD_DATA:  if (tmr_last) state_nx = S_IDLE;
         S_WR_MOD:   state_nx = S_WR_ROW;
         S_WR_ROW:   state_nx = S_WR_COL;
         S_WR_COL:   state_nx = S_WR_NET;
         S_WR_NET:   state_nx = S_WR_ACK;
         S_WR_ACK:   state_nx = S_WR_DATA;
         S_WR_DATA:  if (teardown_in) state_nx = S_IDLE;
         S_ABORT:    state_nx = S_IDLE;
         default:    state_nx = S_IDLE;
      endcase
   end

   assign idle          = (state == S_IDLE);
   assign accept        = idle && req_valid;
   assign tmr_load_wait = (state == S_RD_SETUP);
   assign tmr_load_data = (state == S_RD_COL);
   assign tmr_dec       = (state == S_RD_WAIT) || (state == S_RD_DATA);

   always_comb begin
      sw_mod2mem  = 1'b0;
      sw_mem2net  = 1'b0;
      sw_net2mem  = 1'b0;
      setup_valid = 1'b0;
      ack_out     = 1'b0;
      abort_o     = 1'b0;
      cmd_valid   = 1'b0;
      cmd_kind    = CMD_NONE;
      unique case (state)
         S_RD_SW, S_RD_WAIT: begin
            sw_mod2mem = 1'b1;
            sw_mem2net = 1'b1;
         end
         S_RD_SETUP: begin
            sw_mod2mem  = 1'b1;
            sw_mem2net  = 1'b1;
            setup_valid = 1'b1;
         end
         S_RD_ROW: begin
            sw_mod2mem = 1'b1;
            sw_mem2net = 1'b1;
            cmd_valid  = 1'b1;
            cmd_kind   = CMD_ROW;
         end
         S_RD_COL: begin
            sw_mod2mem = 1'b1;
            sw_mem2net = 1'b1;
            cmd_valid  = 1'b1;
            cmd_kind   = CMD_RD;
         end
         S_RD_DATA: sw_mem2net = 1'b1;
         S_WR_MOD:  sw_mod2mem = 1'b1;
         S_WR_ROW: begin
            sw_mod2mem = 1'b1;
            cmd_valid  = 1'b1;
            cmd_kind   = CMD_ROW;
         end
         S_WR_COL: begin
            sw_mod2mem = 1'b1;
            cmd_valid  = 1'b1;
            cmd_kind   = CMD_WR;
         end
         S_WR_NET, S_WR_DATA: sw_net2mem = 1'b1;
         S_WR_ACK: begin
            sw_net2mem = 1'b1;
            ack_out    = 1'b1;
         end
         S_ABORT: abort_o = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/mgw_seq.sv
// Memory gateway sequencer top: request capture, shared timer and state machine.
module mgw_seq
   import mgw_pkg::*;
#(
   parameter int ROW_W    = 14,
   parameter int COL_W    = 10,
   parameter int LEN_W    = 6,
   parameter int SRC_W    = 6,
   parameter int TO_W     = 8,
   parameter int BEAT_CYC = 4,
   parameter int CL_CYC   = 10,
   localparam int ADDR_W  = ROW_W + COL_W,
   localparam int CMD_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [SRC_W-1:0]  req_src,
   input  logic [TO_W-1:0]   to_limit,
   output logic              sw_mod2mem,
   output logic              sw_mem2net,
   output logic              sw_net2mem,
   output logic              setup_valid,
   input  logic              ack_in,
   output logic              ack_out,
   input  logic              teardown_in,
   output logic [SRC_W-1:0]  peer_id,
   output logic              cmd_valid,
   output logic [1:0]        cmd_kind,
   output logic [CMD_W-1:0]  cmd_addr,
   output logic              abort_o
);

   localparam int DUR_MAX = CL_CYC + ((1 << LEN_W) - 1) * BEAT_CYC;
   localparam int DUR_W   = $clog2(DUR_MAX + 1);
   localparam int TMR_W   = (DUR_W > TO_W) ? DUR_W : TO_W;

   // Elaboration-time parameter checks
   if (ROW_W < 1 || COL_W < 1) begin : g_bad_addr
      $error("mgw_seq: ROW_W and COL_W must be at least 1");
   end
   if (BEAT_CYC < 1) begin : g_bad_beat
      $error("mgw_seq: BEAT_CYC must be at least 1");
   end
   if (CL_CYC < 1) begin : g_bad_cl
      $error("mgw_seq: CL_CYC must be at least 1");
   end
   if (LEN_W < 1 || LEN_W > 16 || TO_W < 1 || SRC_W < 1) begin : g_bad_width
      $error("mgw_seq: LEN_W, TO_W, SRC_W out of range");
   end

   logic             accept, idle;
   logic             tmr_load_wait, tmr_load_data, tmr_dec, tmr_last;
   logic [ROW_W-1:0] h_row;
   logic [COL_W-1:0] h_col;
   logic [LEN_W-1:0] h_len;
   logic [SRC_W-1:0] h_src;
   logic [TMR_W-1:0] wait_val, data_val, tmr_val;
   logic [CMD_W-1:0] row_x, col_x;
   gw_cmd_t          kind;

   mgw_req_reg #(
      .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .SRC_W(SRC_W)
   ) u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .in_row (req_addr[ADDR_W-1:COL_W]),
      .in_col (req_addr[COL_W-1:0]),
      .in_len (req_len),
      .in_src (req_src),
      .row    (h_row),
      .col    (h_col),
      .len    (h_len),
      .src    (h_src)
   );

   // Window of at least one cycle; data time = latency + beats * beat time
   assign wait_val = (to_limit == '0) ? TMR_W'(1) : TMR_W'(to_limit);
   assign data_val = TMR_W'(CL_CYC) + TMR_W'(h_len) * TMR_W'(BEAT_CYC);
   assign tmr_val  = tmr_load_wait ? wait_val : data_val;

   mgw_timer #(.W(TMR_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load_wait || tmr_load_data),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .last     (tmr_last)
   );

   mgw_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .ack_in        (ack_in),
      .teardown_in   (teardown_in),
      .tmr_last      (tmr_last),
      .accept        (accept),
      .idle          (idle),
      .tmr_load_wait (tmr_load_wait),
      .tmr_load_data (tmr_load_data),
      .tmr_dec       (tmr_dec),
      .sw_mod2mem    (sw_mod2mem),
      .sw_mem2net    (sw_mem2net),
      .sw_net2mem    (sw_net2mem),
      .setup_valid   (setup_valid),
      .ack_out       (ack_out),
      .abort_o       (abort_o),
      .cmd_valid     (cmd_valid),
      .cmd_kind      (kind)
   );

   // Align row and column to the common command bus width
   if (ROW_W == COL_W) begin : g_addr_eq
      assign row_x = h_row;
      assign col_x = h_col;
   end else if (ROW_W > COL_W) begin : g_addr_row_wide
      assign row_x = h_row;
      assign col_x = {{(CMD_W-COL_W){1'b0}}, h_col};
   end else begin : g_addr_col_wide
      assign row_x = {{(CMD_W-ROW_W){1'b0}}, h_row};
      assign col_x = h_col;
   end

   assign req_ready = idle;
   assign peer_id   = h_src;
   assign cmd_kind  = kind;
   assign cmd_addr  = !cmd_valid        ? '0    :
                      (kind == CMD_ROW) ? row_x : col_x;

endmodule

// File: rtl/mgw_seq_chk.sv
// Port-level protocol checks for mgw_seq, attached by bind.
module mgw_seq_chk #(
   parameter int SRC_W = 6,
   parameter int CMD_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             sw_mod2mem,
   input logic             sw_mem2net,
   input logic             sw_net2mem,
   input logic             setup_valid,
   input logic             ack_out,
   input logic             teardown_in,
   input logic             cmd_valid,
   input logic [1:0]       cmd_kind,
   input logic [CMD_W-1:0] cmd_addr,
   input logic [SRC_W-1:0] peer_id,
   input logic             abort_o
);

   AST_READY_NO_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(sw_mod2mem || sw_mem2net || sw_net2mem)); // R2
   AST_SETUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      setup_valid |=> !setup_valid); // R3
   AST_SETUP_WITH_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      setup_valid |-> (sw_mod2mem && sw_mem2net && !cmd_valid)); // R3
   AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_kind == 2'd1) |=> (cmd_valid && cmd_kind != 2'd1)); // R4
   AST_CMD_NEEDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> sw_mod2mem); // R4
   AST_ABORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> !(sw_mod2mem || sw_mem2net || sw_net2mem || req_ready)); // R6
   AST_SW_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_mem2net && sw_net2mem)); // R7
   AST_ACK_ON_NET: assert property (@(posedge clk) disable iff (!rst_n)
      ack_out |-> (sw_net2mem && !sw_mod2mem)); // R7
   AST_TEAR_BY_PEER: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sw_net2mem) |-> $past(teardown_in)); // R8

endmodule

bind mgw_seq mgw_seq_chk #(.SRC_W(SRC_W), .CMD_W(CMD_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .sw_mod2mem  (sw_mod2mem),
   .sw_mem2net  (sw_mem2net),
   .sw_net2mem  (sw_net2mem),
   .setup_valid (setup_valid),
   .ack_out     (ack_out),
   .teardown_in (teardown_in),
   .cmd_valid   (cmd_valid),
   .cmd_kind    (cmd_kind),
   .cmd_addr    (cmd_addr),
   .peer_id     (peer_id),
   .abort_o     (abort_o)
);

// File: tb/mgw_seq_bench.sv
module mgw_seq_bench;

   localparam int ROW_W    = 14;
   localparam int COL_W    = 10;
   localparam int LEN_W    = 6;
   localparam int SRC_W    = 6;
   localparam int TO_W     = 8;
   localparam int BEAT_CYC = 4;
   localparam int CL_CYC   = 10;
   localparam int ADDR_W   = ROW_W + COL_W;
   localparam int CMD_W    = (ROW_W > COL_W) ? ROW_W : COL_W;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid, req_ready, req_write;
   logic [ADDR_W-1:0] req_addr;
   logic [LEN_W-1:0]  req_len;
   logic [SRC_W-1:0]  req_src;
   logic [TO_W-1:0]   to_limit;
   logic              sw_mod2mem, sw_mem2net, sw_net2mem;
   logic              setup_valid, ack_in, ack_out, teardown_in;
   logic [SRC_W-1:0]  peer_id;
   logic              cmd_valid;
   logic [1:0]        cmd_kind;
   logic [CMD_W-1:0]  cmd_addr;
   logic              abort_o;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   mgw_seq #(
      .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .SRC_W(SRC_W),
      .TO_W(TO_W), .BEAT_CYC(BEAT_CYC), .CL_CYC(CL_CYC)
   ) u_mgw_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .req_src(req_src), .to_limit(to_limit), .sw_mod2mem(sw_mod2mem),
      .sw_mem2net(sw_mem2net), .sw_net2mem(sw_net2mem),
      .setup_valid(setup_valid), .ack_in(ack_in), .ack_out(ack_out),
      .teardown_in(teardown_in), .peer_id(peer_id), .cmd_valid(cmd_valid),
      .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .abort_o(abort_o)
   );

   function automatic int exp_dur(input int len);
      return CL_CYC + len * BEAT_CYC;
   endfunction

   function automatic int exp_window(input int lim);
      return (lim == 0) ? 1 : lim;
   endfunction

   function automatic logic [2:0] sw3();
      return {sw_mod2mem, sw_mem2net, sw_net2mem};
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_idle(input string tag);
      chk(req_ready == 1'b1, {tag, " ready"}, req_ready, 1);
      chk(sw3() == 3'b000, {tag, " switches"}, sw3(), 0);
      chk(!setup_valid && !ack_out && !cmd_valid && !abort_o, {tag, " strobes"},
          {setup_valid, ack_out, cmd_valid, abort_o}, 0);
   endtask

   // Offer a request at a negedge; it is accepted at the next posedge.
   task automatic offer(input bit wr, input [ROW_W-1:0] row, input [COL_W-1:0] col,
                        input [LEN_W-1:0] len, input [SRC_W-1:0] src);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = {row, col};
      req_len   = len;
      req_src   = src;
      step();
   endtask

   task automatic do_read(input [ROW_W-1:0] row, input [COL_W-1:0] col,
                          input [LEN_W-1:0] len, input [SRC_W-1:0] src,
                          input int ackd, input bit early, input bit noise, input bit hold);
      int n;
      int d;
      n = exp_window(int'(to_limit));
      offer(1'b0, row, col, len, src);
      if (!hold) req_valid = 1'b0;
      // R3: first cycle after accept
      chk(sw3() == 3'b110, "R3 read switches", sw3(), 3'b110);
      chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
      chk(setup_valid == 1'b0, "R3 setup not yet", setup_valid, 0);
      step();
      req_valid = 1'b0;
      chk(setup_valid == 1'b1, "R3 setup pulse", setup_valid, 1);
      chk(peer_id == src, "R3 setup peer", peer_id, src);
      chk(cmd_valid == 1'b0, "R4 no cmd at setup", cmd_valid, 0);
      if (early) ack_in = 1'b1;   // R9: acknowledgement outside the window
      step();
      ack_in = 1'b0;
      for (int w = 1; w <= n; w++) begin
         chk(cmd_valid == 1'b0 && setup_valid == 1'b0, "R4 no cmd while waiting",
             cmd_valid, 0);
         chk(sw3() == 3'b110, "R6 path held in wait", sw3(), 3'b110);
         if (w == ackd) ack_in = 1'b1;
         step();
         ack_in = 1'b0;
         if (w == ackd) break;
      end
      if (ackd < 1 || ackd > n) begin
         chk(abort_o == 1'b1, "R6 abort pulse", abort_o, 1);
         chk(sw3() == 3'b000, "R6 switches released", sw3(), 0);
         chk(cmd_valid == 1'b0, "R9 no cmd after stray ack", cmd_valid, 0);
         step();
         chk(abort_o == 1'b0, "R6 abort one cycle", abort_o, 0);
         chk_idle("R6 idle after abort");
         return;
      end
      chk(cmd_valid && cmd_kind == 2'd1, "R4 row cmd", {cmd_valid, cmd_kind}, 3'b101);
      chk(cmd_addr == CMD_W'(row), "R4 row addr", cmd_addr, row);
      step();
      chk(cmd_valid && cmd_kind == 2'd2, "R4 read col cmd", {cmd_valid, cmd_kind}, 3'b110);
      chk(cmd_addr == CMD_W'(col), "R4 col addr", cmd_addr, col);
      d = exp_dur(int'(len));
      for (int c = 1; c <= d; c++) begin
         step();
         teardown_in = 1'b0;
         chk(sw3() == 3'b010, "R5 data phase switches", sw3(), 3'b010);
         chk(req_ready == 1'b0 && cmd_valid == 1'b0, "R5 data phase busy",
             {req_ready, cmd_valid}, 0);
         if (noise && (c % 3 == 1)) teardown_in = 1'b1;   // R8: ignored on a read
      end
      step();
      teardown_in = 1'b0;
      chk_idle("R5 idle after read");
   endtask

   task automatic do_write(input [ROW_W-1:0] row, input [COL_W-1:0] col,
                           input [SRC_W-1:0] src, input int tdelay, input bit hold);
      offer(1'b1, row, col, 6'd0, src);
      if (!hold) req_valid = 1'b0;
      chk(sw3() == 3'b100, "R7 modulators first", sw3(), 3'b100);
      chk(cmd_valid == 1'b0, "R7 no cmd yet", cmd_valid, 0);
      chk(req_ready == 1'b0, "R2 busy on write", req_ready, 0);
      ack_in = 1'b1;   // R9: no effect on a write
      step();
      req_valid = 1'b0;
      ack_in    = 1'b0;
      chk(cmd_valid && cmd_kind == 2'd1, "R7 row cmd", {cmd_valid, cmd_kind}, 3'b101);
      chk(cmd_addr == CMD_W'(row), "R7 row addr", cmd_addr, row);
      step();
      chk(cmd_valid && cmd_kind == 2'd3, "R7 write col cmd", {cmd_valid, cmd_kind}, 3'b111);
      chk(cmd_addr == CMD_W'(col), "R7 col addr", cmd_addr, col);
      chk(sw3() == 3'b100, "R7 modulators during cmds", sw3(), 3'b100);
      step();
      chk(sw3() == 3'b001, "R7 net path after cmds", sw3(), 3'b001);
      chk(ack_out == 1'b0, "R7 ack not before net path", ack_out, 0);
      teardown_in = 1'b1;   // R8: ignored before the acknowledgement
      step();
      teardown_in = 1'b0;
      chk(ack_out == 1'b1, "R7 ack pulse", ack_out, 1);
      chk(peer_id == src, "R7 ack peer", peer_id, src);
      chk(sw3() == 3'b001, "R8 path held at ack", sw3(), 3'b001);
      for (int t = 1; t <= tdelay; t++) begin
         step();
         teardown_in = 1'b0;
         chk(ack_out == 1'b0, "R7 ack one cycle", ack_out, 0);
         chk(sw3() == 3'b001, "R8 path held until teardown", sw3(), 3'b001);
         if (t == tdelay) teardown_in = 1'b1;
      end
      step();
      teardown_in = 1'b0;
      chk_idle("R8 idle after teardown");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n       = 1'b0;
      req_valid   = 1'b0;
      req_write   = 1'b0;
      req_addr    = '0;
      req_len     = '0;
      req_src     = '0;
      to_limit    = 8'd5;
      ack_in      = 1'b0;
      teardown_in = 1'b0;
      repeat (3) @(negedge clk);
      chk_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("R1 after reset");

      // Directed corners
      do_read(14'h1234, 10'h155, 6'd0, 6'd3, 1, 1'b0, 1'b0, 1'b0);    // R5 len 0
      do_read(14'h3fff, 10'h3ff, 6'd2, 6'd9, 5, 1'b0, 1'b1, 1'b1);    // R6 last window cycle, R8 noise, R2 hold
      do_read(14'h0001, 10'h001, 6'd1, 6'd4, 6, 1'b0, 1'b0, 1'b0);    // R6 timeout
      do_read(14'h0002, 10'h002, 6'd1, 6'd5, 0, 1'b1, 1'b0, 1'b0);    // R9 early ack only
      to_limit = 8'd0;
      do_read(14'h0aaa, 10'h0bb, 6'd3, 6'd6, 1, 1'b0, 1'b0, 1'b0);    // R6 window of one
      do_read(14'h0aab, 10'h0bc, 6'd3, 6'd7, 2, 1'b0, 1'b0, 1'b0);    // R6 one too late
      to_limit = 8'd5;
      do_read(14'h2000, 10'h200, 6'd63, 6'd63, 3, 1'b0, 1'b1, 1'b0);  // R5 longest burst
      do_write(14'h1111, 10'h222, 6'd1, 1, 1'b1);                     // R8 earliest teardown
      do_write(14'h3333, 10'h044, 6'd2, 7, 1'b0);                     // R7 R8

      // Constrained random mix
      for (int k = 0; k < 150; k++) begin
         logic [ROW_W-1:0] r;
         logic [COL_W-1:0] c;
         logic [LEN_W-1:0] l;
         logic [SRC_W-1:0] s;
         int gap;
         r = ROW_W'($urandom);
         c = COL_W'($urandom);
         l = LEN_W'($urandom_range(0, 20));
         s = SRC_W'($urandom);
         to_limit = TO_W'($urandom_range(0, 6));
         gap = $urandom_range(0, 2);
         repeat (gap) begin
            step();
            chk_idle("R2 idle gap");
         end
         if ($urandom_range(0, 1) == 1)
            do_write(r, c, s, $urandom_range(1, 6), 1'($urandom_range(0, 1)));
         else
            do_read(r, c, l, s, $urandom_range(1, exp_window(int'(to_limit)) + 2),
                    1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)));
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule